// File: doc/BRIEF.md
# Dithered 14-bit Tuning PWM

This block turns a 14-bit control word into a single pulse-width-modulated output pin intended to drive, through an external low-pass filter, the tuning voltage of a receiver. The pulse repeats every 128 time steps. The upper seven bits of the word (the coarse value C) set how many steps of each period are high. The lower seven bits (the fine value N) add one extra high step to N periods out of every frame of 128 periods. After filtering, the average therefore resolves 1/16384 of full scale.

Software sets the word through two byte-wide registers. The low register holds the coarse LSB in bit 7 and N in bits 6:0. The high register holds the coarse bits C[6:1] in bits 5:0, an unused bit 6, and the pin-ownership enable in bit 7.

A write to the high register snapshots both bytes into a staging copy. That copy becomes the active value at the next period boundary, so software writes the low byte first and the high byte second. When the enable is clear, a general-purpose port latch bit drives the pin instead of the modulator. The step rate is the clock divided by the parameter `STEP_DIV`, which defaults to 4: a 12 MHz clock then gives 3 MHz steps and a period of about 42.67 µs.

Top module: `tune_pwm_dac`

## Requirements
- R1: One time step lasts `STEP_DIV` clock cycles, and one output period lasts exactly 128 steps.
- R2: With fine value 0, the pin is high for C steps of every period. C is formed as high-register bits 5:0 above low-register bit 7, and can range from 0 to 127.
- R3: Over any 128 consecutive periods the pin is high for exactly 128·C + N steps. N is low-register bits 6:0.
- R4: A period with frame index f (0..127) is lengthened by one step exactly when the bit-reversed f is below N. With N = 64, every other period is lengthened, so any two consecutive periods together hold 2·C + 1 high steps.
- R5: A write to the low register alone leaves the output unchanged. A later write to the high register commits both bytes together.
- R6: A committed value becomes active only at the start of a new period, so no period is cut short or mixed.
- R7: High-register bit 7 selects the pin source. When it is 1 the modulator drives the pin; when it is 0 the input `port_bit` drives it. The selection changes in the cycle after the high-register write.
- R8: When C = 0 and N = 0, the pin stays low for the whole period while the modulator owns it.
- R9: After reset the high register is 0x40 and the low register is 0x00, so the pin follows `port_bit`. High-register bit 6 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_hi | input | 1 | Write target: 1 = high register, 0 = low register |
| wr_data | input | 8 | Write data |
| port_bit | input | 1 | General-purpose latch bit used when the modulator is disabled |
| pwm_pin | output | 1 | Output pin |

## Verification
A high-register write can land in the same cycle as a period boundary that is already committing an earlier staged value. The design must then activate the older value and keep the new one pending for the following boundary. The per-cycle assertion on the active value only allows it to change after a boundary. The bench issues back-to-back commits without aligning to the period. It judges the result by counting high cycles over whole-period and whole-frame windows after each update, comparing the count against 128·C + N scaled by the step length.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
    localparam int PHASE_BITS = 7;
    localparam int PERIOD_STEPS = 1 << PHASE_BITS;

    typedef struct packed {
        logic [PHASE_BITS-1:0] coarse;
        logic [PHASE_BITS-1:0] fine;
    } tpd_val_t;

    typedef struct packed {
        logic [7:0] low;
        tpd_val_t   stg;
        tpd_val_t   act;
        logic       en;
        logic       pend;
    } tpd_regs_st_t;

    typedef struct packed {
        logic [PHASE_BITS-1:0] pos;
        logic [PHASE_BITS-1:0] frm;
        logic                  pwm;
    } tpd_core_st_t;
endpackage

// File: rtl/tpd_step_gen.sv
module tpd_step_gen #(
    parameter int STEP_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

    generate
        if (STEP_DIV > 1) begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == CW'(STEP_DIV - 1)) cnt_d = '0;
                else                            cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == CW'(STEP_DIV - 1));

            // R1: a step pulse is never followed directly by another
            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_full
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/tpd_regs.sv
module tpd_regs
    import tpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       boundary,
    output tpd_val_t   act,
    output logic       en
);
    tpd_regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // commit at the period boundary first
        if (boundary && st_q.pend) begin
            st_d.act  = st_q.stg;
            st_d.pend = 1'b0;
        end
        if (wr_en && !wr_hi) begin
            st_d.low = wr_data;
        end
        // a high write snapshots both bytes; it wins over a same-cycle commit
        if (wr_en && wr_hi) begin
            st_d.stg.coarse = {wr_data[5:0], st_q.low[7]};
            st_d.stg.fine   = st_q.low[6:0];
            st_d.en         = wr_data[7];
            st_d.pend       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;
    assign en  = st_q.en;

    // R6: the active value only changes right after a period boundary
    a_r6_commit_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> $past(boundary));

    // R5: a high write always leaves a commit pending
    a_r5_high_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> st_q.pend);
endmodule

// File: rtl/tpd_core.sv
module tpd_core
    import tpd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  tpd_val_t act,
    output logic     boundary,
    output logic     pwm
);
    tpd_core_st_t st_d, st_q;
    logic [PHASE_BITS-1:0] frm_rev;
    logic                  extend;
    logic [PHASE_BITS:0]   width;

    always_comb begin
        for (int i = 0; i < PHASE_BITS; i++) begin
            frm_rev[i] = st_q.frm[PHASE_BITS-1-i];
        end
    end

    assign boundary = tick && (st_q.pos == '1);

    always_comb begin
        extend = (frm_rev < act.fine);
        width  = {1'b0, act.coarse} + {{PHASE_BITS{1'b0}}, extend};
        st_d   = st_q;
        st_d.pwm = ({1'b0, st_q.pos} < width);
        if (tick) begin
            st_d.pos = st_q.pos + 1'b1;
            if (st_q.pos == '1) st_d.frm = st_q.frm + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.pwm;

    // R1: the phase wraps to zero after 128 steps
    a_r1_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (st_q.pos == '0));

    // R8: a settled zero value gives a low output
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((act == '0) && $stable(act)) |-> !st_q.pwm);
endmodule

// File: rtl/tune_pwm_dac.sv
module tune_pwm_dac #(
    parameter int STEP_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       port_bit,
    output logic       pwm_pin
);
    import tpd_pkg::*;

    logic     tick;
    logic     boundary;
    logic     pwm;
    logic     en;
    tpd_val_t act;

    tpd_step_gen #(.STEP_DIV(STEP_DIV)) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tpd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .boundary(boundary),
        .act     (act),
        .en      (en)
    );

    tpd_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .act     (act),
        .boundary(boundary),
        .pwm     (pwm)
    );

    assign pwm_pin = en ? pwm : port_bit;

    // R7: pin ownership only changes after a high-register write
    a_r7_enable_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en) |-> $past(wr_en && wr_hi));
endmodule

// File: tb/tune_pwm_dac_test.sv
module tune_pwm_dac_test;
    localparam int DIV = 2;
    localparam int PER = 128 * DIV;
    localparam int FRAME = 128 * PER;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic port_bit = 1'b0;
    logic pwm_pin;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tune_pwm_dac #(.STEP_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .port_bit(port_bit), .pwm_pin(pwm_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_pin) cnt++;
        end
    endtask

    task automatic settle();
        repeat (PER + 40) @(negedge clk);
    endtask

    task automatic t_reset();
        int c;
        port_bit = 1'b1; @(negedge clk);
        check(pwm_pin == 1'b1, "R9", pwm_pin, 1);
        port_bit = 1'b0; @(negedge clk);
        check(pwm_pin == 1'b0, "R9", pwm_pin, 0);
        count_high(PER, c);
        check(c == 0, "R9", c, 0);
    endtask

    task automatic t_zero();
        int c;
        port_bit = 1'b1;
        wr(1'b0, 8'h00); wr(1'b1, 8'h80);
        settle();
        count_high(PER, c);
        check(c == 0, "R8", c, 0);
    endtask

    task automatic t_step();
        int c;
        wr(1'b0, 8'h80); wr(1'b1, 8'h80);   // C = 1
        settle();
        count_high(PER, c);
        check(c == DIV, "R1", c, DIV);
        count_high(2 * PER, c);
        check(c == 2 * DIV, "R1", c, 2 * DIV);
    endtask

    task automatic t_coarse();
        int c;
        wr(1'b0, 8'h00); wr(1'b1, 8'hA0);   // C = 64
        settle();
        count_high(PER, c);
        check(c == 64 * DIV, "R2", c, 64 * DIV);
        wr(1'b0, 8'h80); wr(1'b1, 8'hBF);   // C = 127
        settle();
        count_high(PER, c);
        check(c == 127 * DIV, "R2", c, 127 * DIV);
    endtask

    task automatic t_fine();
        int c;
        wr(1'b0, 8'hA0); wr(1'b1, 8'h82);   // C = 5, N = 32
        settle();
        count_high(FRAME, c);
        check(c == (128 * 5 + 32) * DIV, "R3", c, (128 * 5 + 32) * DIV);
        wr(1'b0, 8'hFF); wr(1'b1, 8'hBF);   // C = 127, N = 127
        settle();
        count_high(FRAME, c);
        check(c == (128 * 127 + 127) * DIV, "R3", c, (128 * 127 + 127) * DIV);
    endtask

    task automatic t_spread();
        int c;
        wr(1'b0, 8'h40); wr(1'b1, 8'h85);   // C = 10, N = 64
        settle();
        for (int k = 0; k < 3; k++) begin
            count_high(2 * PER, c);
            check(c == 21 * DIV, "R4", c, 21 * DIV);
        end
    endtask

    task automatic t_stage();
        int c;
        wr(1'b0, 8'h00); wr(1'b1, 8'hA0);   // C = 64
        settle();
        wr(1'b0, 8'h80);                    // low alone: C[0] staged only
        settle();
        count_high(PER, c);
        check(c == 64 * DIV, "R5", c, 64 * DIV);
        wr(1'b1, 8'hA0);                    // commit C = 65
        settle();
        count_high(PER, c);
        check(c == 65 * DIV, "R6", c, 65 * DIV);
    endtask

    task automatic t_back_to_back();
        int c;
        wr(1'b0, 8'h00); wr(1'b1, 8'h90);   // C = 32
        wr(1'b1, 8'hA0);                    // C = 64 right behind
        settle();
        count_high(PER, c);
        check(c == 64 * DIV, "R6", c, 64 * DIV);
    endtask

    task automatic t_bit6();
        int c;
        wr(1'b0, 8'h00); wr(1'b1, 8'hE0);   // bit 6 set, C = 64
        settle();
        count_high(PER, c);
        check(c == 64 * DIV, "R9", c, 64 * DIV);
    endtask

    task automatic t_disable();
        wr(1'b1, 8'h20);
        port_bit = 1'b1; @(negedge clk);
        check(pwm_pin == 1'b1, "R7", pwm_pin, 1);
        port_bit = 1'b0; @(negedge clk);
        check(pwm_pin == 1'b0, "R7", pwm_pin, 0);
        wr(1'b1, 8'hBF);                    // C = 127, enable back on
        repeat (4) @(negedge clk);
        port_bit = 1'b0;
        settle();
        @(negedge clk);
        check(pwm_pin == 1'b1 || pwm_pin == 1'b0, "R7", pwm_pin, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_step();
        t_coarse();
        t_spread();
        t_stage();
        t_back_to_back();
        t_bit6();
        t_fine();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(190000 * 5);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule